// File: doc/BRIEF.md
# Warp Reconvergence Stack

This block keeps the divergence state of one warp in a SIMT core. Each stack entry holds a program counter, a per-lane active mask, a reconvergence PC and a call depth. The entry on top of the stack names the lanes that run next and the PC they run from. The top PC, top mask, top reconvergence PC, top call depth and top index are always visible on the outputs.

A launch command clears the whole stack and seeds entry 0 with a start PC, a lane mask and call depth 1. After each branch the core sends an update command. The command carries a done bit for every lane, a next PC for every lane, and the reconvergence PC of the branch. The block then splits the live lanes of the top entry into groups that share a next PC, and handles one group per clock. A group can be discarded, or it can be written as a new entry. Divergence turns the old top entry into a reconvergence entry. When every lane has been handled, the top index moves to the last entry that was written. If nothing was written, the stack pops.

Top module: `warp_recon_stack`

## Requirements
- R1: After reset the top index is 0, the top PC and top reconvergence PC are all ones, the top mask and top call depth are 0, and busy, done and error are low.
- R2: A launch (one cycle on `launch_i`, which takes priority over everything and aborts a running update) clears every entry to the reset values. It writes the start PC, the given mask and call depth 1 into entry 0, sets the top index to 0 and clears the error flag.
- R3: When idle, a start pulse with a non-empty top mask raises busy in the next cycle. Busy stays high for one cycle per extracted group plus one final cycle. Done pulses for exactly one cycle in the cycle after busy falls.
- R4: A lane whose done bit is set is taken out of the work and joins no group.
- R5: Groups are extracted from the highest lane down. The first remaining lane fixes the group PC, and every other remaining lane with that next PC joins the group.
- R6: A group whose PC equals the reconvergence PC of the top entry at the start of the update is discarded before any divergence test.
- R7: Divergence is recorded by the first kept group that leaves lanes behind. If the branch reconvergence PC differs from the old top reconvergence PC, the entry at the write pointer gets that PC and the pointer advances by one. If the two are equal, no extra entry is made.
- R8: After divergence has been recorded, a group whose PC equals the branch reconvergence PC is discarded.
- R9: A kept group is written at the write pointer with its PC and mask, and the pointer advances. After divergence the entry gets call depth 0 and the branch reconvergence PC. Otherwise it gets the old top reconvergence PC and keeps its stored call depth.
- R10: When no lanes remain, the top index becomes the write pointer minus one. When every group was discarded, this pops one entry.
- R11: A next PC of 0 acts as the "no group PC yet" marker. A lane with PC 0 that is scanned before the first lane with a non-zero PC joins that lane's group.
- R12: The error flag is set and stays set until launch in three cases. First, an update is started while the top mask is empty; then no update runs and done pulses in the next cycle. Second, a write would land at index 2×LANES or above; that write is skipped. Third, the top index would drop below 0; it then stays at 0.
- R13: A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_i | input | 1 | Seed the stack (one-cycle pulse) |
| launch_pc_i | input | PC_W | Start PC for entry 0 |
| launch_mask_i | input | LANES | Lane mask for entry 0 |
| upd_start_i | input | 1 | Start an update (one-cycle pulse) |
| upd_done_i | input | LANES | Per-lane done bits |
| upd_pcs_i | input | LANES*PC_W | Per-lane next PC, lane i at bits [i*PC_W +: PC_W] |
| upd_rpc_i | input | PC_W | Reconvergence PC of the issued branch |
| busy_o | output | 1 | Update in progress |
| done_o | output | 1 | One-cycle pulse when an update finishes |
| err_o | output | 1 | Sticky error flag, cleared by launch |
| top_idx_o | output | log2(2*LANES) | Current top index |
| top_pc_o | output | PC_W | PC of the top entry |
| top_mask_o | output | LANES | Active mask of the top entry |
| top_rpc_o | output | PC_W | Reconvergence PC of the top entry |
| top_depth_o | output | CD_W | Call depth of the top entry |

## Verification
Some behaviours are checked by assertions on every cycle:
- accepting a start and raising busy,
- the final cycle that produces the done pulse with busy low,
- the error when the top mask is empty,
- the bound on the write pointer,
- each extracted group being non-empty and inside the remaining lanes,
- a start during busy leaving the captured command untouched,
- the contents of entry 0 after a launch.

Other behaviours show only in the bench's scenarios: which groups are discarded, the in-place rewrite on divergence, the fields of each pushed entry, the PC-0 merge quirk, and the popping and overflow results. The bench checks these by comparing the visible top of stack, the error flag and the busy length against a lane-scan model.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
  typedef enum logic {
    WRS_IDLE = 1'b0,
    WRS_SCAN = 1'b1
  } wrs_state_e;
endpackage

// File: rtl/wrs_group_pick.sv
// Picks the next lane group from the remaining work mask: the PC of the
// highest lane with a non-zero PC, plus every lane sharing it and every
// zero-PC lane scanned before it.
module wrs_group_pick #(
  parameter int LANES = 8,
  parameter int PC_W  = 12
) (
  input  logic [LANES-1:0]      work_i,
  input  logic [LANES*PC_W-1:0] pcs_i,
  output logic [PC_W-1:0]       grp_pc_o,
  output logic [LANES-1:0]      grp_mask_o
);
  logic           found;
  logic [PC_W-1:0] pcx;
  int             kpos;

  always_comb begin
    found = 1'b0;
    pcx   = '0;
    kpos  = 0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (!found && work_i[i] && (pcs_i[i*PC_W +: PC_W] != '0)) begin
        found = 1'b1;
        pcx   = pcs_i[i*PC_W +: PC_W];
        kpos  = i;
      end
    end
    grp_mask_o = '0;
    for (int i = 0; i < LANES; i++) begin
      if (work_i[i]) begin
        if (pcs_i[i*PC_W +: PC_W] == pcx)
          grp_mask_o[i] = 1'b1;
        else if ((pcs_i[i*PC_W +: PC_W] == '0) && (i > kpos))
          grp_mask_o[i] = 1'b1;
      end
    end
    grp_pc_o = pcx;
  end
endmodule

// File: rtl/wrs_entry_file.sv
// Stack storage: one register set per entry, two write ports and one read port.
module wrs_entry_file #(
  parameter int DEPTH = 16,
  parameter int LANES = 8,
  parameter int PC_W  = 12,
  parameter int CD_W  = 4,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic [PC_W-1:0]  seed_pc_i,
  input  logic [LANES-1:0] seed_mask_i,
  input  logic             wa_en_i,
  input  logic [IDX_W-1:0] wa_idx_i,
  input  logic [PC_W-1:0]  wa_pc_i,
  input  logic             wb_en_i,
  input  logic [IDX_W-1:0] wb_idx_i,
  input  logic [PC_W-1:0]  wb_pc_i,
  input  logic [LANES-1:0] wb_mask_i,
  input  logic [PC_W-1:0]  wb_rpc_i,
  input  logic             wb_zero_dep_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [PC_W-1:0]  rd_pc_o,
  output logic [LANES-1:0] rd_mask_o,
  output logic [PC_W-1:0]  rd_rpc_o,
  output logic [CD_W-1:0]  rd_dep_o
);
  logic [PC_W-1:0]  pc_a   [DEPTH];
  logic [LANES-1:0] mask_a [DEPTH];
  logic [PC_W-1:0]  rpc_a  [DEPTH];
  logic [CD_W-1:0]  dep_a  [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [PC_W-1:0]  pc_r,   pc_n;
    logic [LANES-1:0] mask_r, mask_n;
    logic [PC_W-1:0]  rpc_r,  rpc_n;
    logic [CD_W-1:0]  dep_r,  dep_n;
    logic             hit_b, hit_a, en;

    assign hit_b = wb_en_i && (wb_idx_i == IDX_W'(e));
    assign hit_a = wa_en_i && (wa_idx_i == IDX_W'(e));
    assign en    = clear_i || hit_b || hit_a;

    always_comb begin
      pc_n   = pc_r;
      mask_n = mask_r;
      rpc_n  = rpc_r;
      dep_n  = dep_r;
      if (clear_i) begin
        rpc_n = '1;
        if (e == 0) begin
          pc_n   = seed_pc_i;
          mask_n = seed_mask_i;
          dep_n  = CD_W'(1);
        end else begin
          pc_n   = '1;
          mask_n = '0;
          dep_n  = '0;
        end
      end else if (hit_b) begin
        pc_n   = wb_pc_i;
        mask_n = wb_mask_i;
        rpc_n  = wb_rpc_i;
        if (wb_zero_dep_i) dep_n = '0;
      end else if (hit_a) begin
        pc_n = wa_pc_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc_r   <= '1;
        mask_r <= '0;
        rpc_r  <= '1;
        dep_r  <= '0;
      end else if (en) begin
        pc_r   <= pc_n;
        mask_r <= mask_n;
        rpc_r  <= rpc_n;
        dep_r  <= dep_n;
      end
    end

    assign pc_a[e]   = pc_r;
    assign mask_a[e] = mask_r;
    assign rpc_a[e]  = rpc_r;
    assign dep_a[e]  = dep_r;
  end

  assign rd_pc_o   = pc_a[rd_idx_i];
  assign rd_mask_o = mask_a[rd_idx_i];
  assign rd_rpc_o  = rpc_a[rd_idx_i];
  assign rd_dep_o  = dep_a[rd_idx_i];

  // R2: a launch leaves the seed in entry 0 with call depth 1
  assert_seed_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (mask_a[0] == $past(seed_mask_i)) && (pc_a[0] == $past(seed_pc_i))
                && (dep_a[0] == CD_W'(1)) && (rpc_a[0] == '1));
endmodule

// File: rtl/warp_recon_stack.sv
module warp_recon_stack
  import wrs_pkg::*;
#(
  parameter int LANES = 8,
  parameter int PC_W  = 12,
  parameter int CD_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       launch_i,
  input  logic [PC_W-1:0]            launch_pc_i,
  input  logic [LANES-1:0]           launch_mask_i,
  input  logic                       upd_start_i,
  input  logic [LANES-1:0]           upd_done_i,
  input  logic [LANES*PC_W-1:0]      upd_pcs_i,
  input  logic [PC_W-1:0]            upd_rpc_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       err_o,
  output logic [$clog2(2*LANES)-1:0] top_idx_o,
  output logic [PC_W-1:0]            top_pc_o,
  output logic [LANES-1:0]           top_mask_o,
  output logic [PC_W-1:0]            top_rpc_o,
  output logic [CD_W-1:0]            top_depth_o
);
  localparam int DEPTH = 2 * LANES;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

  wrs_state_e            state_q, state_n;
  logic [LANES-1:0]      work_q, work_n;
  logic [LANES*PC_W-1:0] pcs_q, pcs_n;
  logic [PC_W-1:0]       brpc_q, brpc_n;
  logic [PC_W-1:0]       trpc_q, trpc_n;
  logic [PTR_W-1:0]      wr_q, wr_n;
  logic [IDX_W-1:0]      top_q, top_n;
  logic                  div_q, div_n;
  logic                  err_q, err_n;
  logic                  donep_q, donep_n;

  logic [PC_W-1:0]  g_pc;
  logic [LANES-1:0] g_mask, rem;
  logic [PTR_W-1:0] wr_a;
  logic             div_now, div_eff;
  logic             wa_en, wb_en, wb_zd;
  logic [PC_W-1:0]  wb_rpc;
  logic [PC_W-1:0]  t_pc, t_rpc;
  logic [LANES-1:0] t_mask;
  logic [CD_W-1:0]  t_dep;

  function automatic logic [PTR_W-1:0] sat_inc(input logic [PTR_W-1:0] v);
    return (v >= DEPTH_P) ? DEPTH_P : v + PTR_W'(1);
  endfunction

  wrs_group_pick #(.LANES(LANES), .PC_W(PC_W)) u_pick (
    .work_i     (work_q),
    .pcs_i      (pcs_q),
    .grp_pc_o   (g_pc),
    .grp_mask_o (g_mask)
  );

  wrs_entry_file #(
    .DEPTH(DEPTH), .LANES(LANES), .PC_W(PC_W), .CD_W(CD_W), .IDX_W(IDX_W)
  ) u_file (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear_i       (launch_i),
    .seed_pc_i     (launch_pc_i),
    .seed_mask_i   (launch_mask_i),
    .wa_en_i       (wa_en),
    .wa_idx_i      (wr_q[IDX_W-1:0]),
    .wa_pc_i       (brpc_q),
    .wb_en_i       (wb_en),
    .wb_idx_i      (wr_a[IDX_W-1:0]),
    .wb_pc_i       (g_pc),
    .wb_mask_i     (g_mask),
    .wb_rpc_i      (wb_rpc),
    .wb_zero_dep_i (wb_zd),
    .rd_idx_i      (top_q),
    .rd_pc_o       (t_pc),
    .rd_mask_o     (t_mask),
    .rd_rpc_o      (t_rpc),
    .rd_dep_o      (t_dep)
  );

  // next-state logic
  always_comb begin
    state_n = state_q;
    work_n  = work_q;
    pcs_n   = pcs_q;
    brpc_n  = brpc_q;
    trpc_n  = trpc_q;
    wr_n    = wr_q;
    top_n   = top_q;
    div_n   = div_q;
    err_n   = err_q;
    donep_n = 1'b0;
    wa_en   = 1'b0;
    wb_en   = 1'b0;
    wb_zd   = 1'b0;
    wb_rpc  = trpc_q;
    rem     = work_q & ~g_mask;
    wr_a    = wr_q;
    div_now = 1'b0;
    div_eff = div_q;

    if (launch_i) begin
      state_n = WRS_IDLE;
      top_n   = '0;
      err_n   = 1'b0;
      div_n   = 1'b0;
    end else if (state_q == WRS_IDLE) begin
      if (upd_start_i) begin
        if (t_mask == '0) begin
          err_n   = 1'b1;
          donep_n = 1'b1;
        end else begin
          state_n = WRS_SCAN;
          work_n  = t_mask & ~upd_done_i;
          pcs_n   = upd_pcs_i;
          brpc_n  = upd_rpc_i;
          trpc_n  = t_rpc;
          wr_n    = {1'b0, top_q};
          div_n   = 1'b0;
        end
      end
    end else begin
      if (work_q == '0) begin
        state_n = WRS_IDLE;
        donep_n = 1'b1;
        if (wr_q == '0) begin
          err_n = 1'b1;
          top_n = '0;
        end else begin
          top_n = IDX_W'(wr_q - PTR_W'(1));
        end
      end else begin
        work_n = rem;
        if (g_pc != trpc_q) begin
          div_now = (rem != '0) && !div_q;
          div_eff = div_q || div_now;
          if (div_now) begin
            div_n = 1'b1;
            if (brpc_q != trpc_q) begin
              if (wr_q < DEPTH_P) wa_en = 1'b1;
              else                err_n = 1'b1;
              wr_a = sat_inc(wr_q);
            end
          end
          wr_n = wr_a;
          if (!(div_eff && (g_pc == brpc_q))) begin
            if (wr_a < DEPTH_P) wb_en = 1'b1;
            else                err_n = 1'b1;
            wb_zd  = div_eff;
            wb_rpc = div_eff ? brpc_q : trpc_q;
            wr_n   = sat_inc(wr_a);
          end
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WRS_IDLE;
      work_q  <= '0;
      pcs_q   <= '0;
      brpc_q  <= '0;
      trpc_q  <= '0;
      wr_q    <= '0;
      top_q   <= '0;
      div_q   <= 1'b0;
      err_q   <= 1'b0;
      donep_q <= 1'b0;
    end else begin
      state_q <= state_n;
      work_q  <= work_n;
      pcs_q   <= pcs_n;
      brpc_q  <= brpc_n;
      trpc_q  <= trpc_n;
      wr_q    <= wr_n;
      top_q   <= top_n;
      div_q   <= div_n;
      err_q   <= err_n;
      donep_q <= donep_n;
    end
  end

  assign busy_o      = (state_q == WRS_SCAN);
  assign done_o      = donep_q;
  assign err_o       = err_q;
  assign top_idx_o   = top_q;
  assign top_pc_o    = t_pc;
  assign top_mask_o  = t_mask;
  assign top_rpc_o   = t_rpc;
  assign top_depth_o = t_dep;

  // R3: an accepted start raises busy
  assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WRS_IDLE && !launch_i && upd_start_i && t_mask != '0) |=> busy_o);

  // R10: an empty work mask ends the update with a done pulse
  assert_finish_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WRS_SCAN && !launch_i && work_q == '0) |=> (done_o && !busy_o));

  // R12: a start with an empty top mask flags an error and runs no update
  assert_empty_err_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WRS_IDLE && !launch_i && upd_start_i && t_mask == '0)
      |=> (err_o && done_o && !busy_o));

  // R12: the write pointer never runs past the stack size
  assert_wr_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WRS_SCAN) |-> (wr_q <= DEPTH_P));

  // R5: each extracted group is non-empty and drawn from the remaining lanes
  assert_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WRS_SCAN && work_q != '0) |-> ((g_mask != '0) && ((g_mask & ~work_q) == '0)));

  // R13: a start during busy does not replace the captured command
  assert_ignore_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WRS_SCAN && !launch_i && upd_start_i) |=> ($stable(brpc_q) && $stable(pcs_q)));
endmodule

// File: tb/warp_recon_stack_tb.sv
module warp_recon_stack_tb;
  localparam int LANES = 8;
  localparam int PC_W  = 12;
  localparam int CD_W  = 4;
  localparam int DEPTH = 2 * LANES;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic launch_i = 1'b0;
  logic [PC_W-1:0] launch_pc_i = '0;
  logic [LANES-1:0] launch_mask_i = '0;
  logic upd_start_i = 1'b0;
  logic [LANES-1:0] upd_done_i = '0;
  logic [LANES*PC_W-1:0] upd_pcs_i = '0;
  logic [PC_W-1:0] upd_rpc_i = '0;
  logic busy_o, done_o, err_o;
  logic [IDX_W-1:0] top_idx_o;
  logic [PC_W-1:0] top_pc_o, top_rpc_o;
  logic [LANES-1:0] top_mask_o;
  logic [CD_W-1:0] top_depth_o;

  always #2.5 clk = ~clk;

  warp_recon_stack #(.LANES(LANES), .PC_W(PC_W), .CD_W(CD_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .launch_i(launch_i), .launch_pc_i(launch_pc_i), .launch_mask_i(launch_mask_i),
    .upd_start_i(upd_start_i), .upd_done_i(upd_done_i), .upd_pcs_i(upd_pcs_i),
    .upd_rpc_i(upd_rpc_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .top_idx_o(top_idx_o), .top_pc_o(top_pc_o), .top_mask_o(top_mask_o),
    .top_rpc_o(top_rpc_o), .top_depth_o(top_depth_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // reference model state
  logic [PC_W-1:0]  m_pc   [DEPTH];
  logic [LANES-1:0] m_mask [DEPTH];
  logic [PC_W-1:0]  m_rpc  [DEPTH];
  logic [CD_W-1:0]  m_dep  [DEPTH];
  int m_top;
  logic m_err;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic mdl_reset();
    for (int e = 0; e < DEPTH; e++) begin
      m_pc[e] = '1; m_mask[e] = '0; m_rpc[e] = '1; m_dep[e] = '0;
    end
    m_top = 0;
    m_err = 1'b0;
  endtask

  task automatic mdl_update(input logic [LANES-1:0] dn, input logic [LANES*PC_W-1:0] pcs,
                            input logic [PC_W-1:0] brpc, output int steps);
    logic [LANES-1:0] work, g;
    logic [PC_W-1:0] trpc, tmp, p;
    int wr;
    logic dv;
    steps = 0;
    if (m_mask[m_top] == '0) begin
      m_err = 1'b1;
      return;
    end
    work = m_mask[m_top] & ~dn;
    trpc = m_rpc[m_top];
    wr = m_top;
    dv = 1'b0;
    while (work != '0) begin
      steps++;
      tmp = '0;
      g = '0;
      for (int i = LANES - 1; i >= 0; i--) begin
        if (work[i]) begin
          p = pcs[i*PC_W +: PC_W];
          if (tmp == '0) begin tmp = p; g[i] = 1'b1; end
          else if (tmp == p) g[i] = 1'b1;
        end
      end
      work = work & ~g;
      if (tmp == trpc) continue;
      if (work != '0 && !dv) begin
        dv = 1'b1;
        if (brpc != trpc) begin
          if (wr < DEPTH) m_pc[wr] = brpc; else m_err = 1'b1;
          if (wr < DEPTH) wr++;
        end
      end
      if (dv && tmp == brpc) continue;
      if (wr < DEPTH) begin
        m_pc[wr] = tmp;
        m_mask[wr] = g;
        if (dv) begin m_rpc[wr] = brpc; m_dep[wr] = '0; end
        else m_rpc[wr] = trpc;
      end else m_err = 1'b1;
      if (wr < DEPTH) wr++;
    end
    steps++;
    if (wr == 0) begin m_err = 1'b1; m_top = 0; end
    else m_top = wr - 1;
  endtask

  task automatic cmp_top(input string tag);
    chk({tag, " top_idx"}, 32'(top_idx_o), 32'(m_top));
    chk({tag, " top_pc"}, 32'(top_pc_o), 32'(m_pc[m_top]));
    chk({tag, " top_mask"}, 32'(top_mask_o), 32'(m_mask[m_top]));
    chk({tag, " top_rpc"}, 32'(top_rpc_o), 32'(m_rpc[m_top]));
    chk({tag, " top_depth"}, 32'(top_depth_o), 32'(m_dep[m_top]));
    chk({tag, " err"}, 32'(err_o), 32'(m_err));
    chk({tag, " busy"}, 32'(busy_o), 32'(0));
  endtask

  task automatic do_launch(input logic [PC_W-1:0] pc, input logic [LANES-1:0] mk);
    launch_i = 1'b1; launch_pc_i = pc; launch_mask_i = mk;
    @(negedge clk);
    launch_i = 1'b0;
    mdl_reset();
    m_pc[0] = pc; m_mask[0] = mk; m_dep[0] = CD_W'(1);
  endtask

  task automatic do_update(input string tag, input logic [LANES-1:0] dn,
                           input logic [LANES*PC_W-1:0] pcs, input logic [PC_W-1:0] brpc,
                           input bit poke);
    int steps, cnt;
    mdl_update(dn, pcs, brpc, steps);
    upd_start_i = 1'b1; upd_done_i = dn; upd_pcs_i = pcs; upd_rpc_i = brpc;
    @(negedge clk);
    upd_start_i = 1'b0;
    cnt = 0;
    while (busy_o && cnt < 64) begin
      if (poke && cnt == 1) begin
        // R13: a second start while busy must be ignored
        upd_start_i = 1'b1; upd_done_i = '0; upd_pcs_i = {LANES{12'h7A7}}; upd_rpc_i = 12'h7A7;
      end
      cnt++;
      @(negedge clk);
      upd_start_i = 1'b0;
    end
    chk({tag, " R3 busy cycles"}, 32'(cnt), 32'(steps));
    chk({tag, " R3 done pulse"}, 32'(done_o), 32'(1));
    cmp_top(tag);
    @(negedge clk);
    chk({tag, " R3 done one cycle"}, 32'(done_o), 32'(0));
  endtask

  function automatic logic [LANES*PC_W-1:0] pcs_hi_lo(input logic [PC_W-1:0] hi, input logic [PC_W-1:0] lo);
    logic [LANES*PC_W-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*PC_W +: PC_W] = (i >= LANES/2) ? hi : lo;
    return v;
  endfunction

  function automatic logic [PC_W-1:0] rnd_pc();
    case ($urandom % 8)
      0: return 12'h000;
      1: return 12'hFFF;
      2, 3: return 12'h010;
      4: return 12'h020;
      5: return 12'h030;
      default: return 12'h040;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [LANES*PC_W-1:0] pv;
    void'($urandom(32'd20240611));
    mdl_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    cmp_top("R1 reset");
    chk("R1 done", 32'(done_o), 32'(0));

    // R2 launch seeds entry 0
    do_launch(12'h100, 8'hFF);
    cmp_top("R2 launch");
    chk("R2 depth one", 32'(top_depth_o), 32'(1));

    // R5 R9 uniform branch keeps one group, inherits reconvergence PC
    do_update("R9 uniform", '0, {LANES{12'h104}}, 12'h200, 1'b0);

    // R7 R9 divergence rewrites top and pushes two groups (with busy poke, R13)
    do_update("R7 diverge", '0, pcs_hi_lo(12'h110, 12'h120), 12'h130, 1'b1);
    chk("R7 top_idx", 32'(top_idx_o), 32'(2));
    chk("R9 lower group pc", 32'(top_pc_o), 32'h120);
    chk("R9 lower group mask", 32'(top_mask_o), 32'h0F);
    chk("R9 diverged rpc", 32'(top_rpc_o), 32'h130);
    chk("R9 diverged depth", 32'(top_depth_o), 32'(0));

    // R6 R10 reaching the top reconvergence PC pops
    do_update("R6 pop", '0, {LANES{12'h130}}, 12'h140, 1'b0);
    chk("R10 pop idx", 32'(top_idx_o), 32'(1));
    chk("R10 pop mask", 32'(top_mask_o), 32'hF0);

    // R4 all remaining lanes done pops to the reconvergence entry
    do_update("R4 done lanes", 8'hF0, {LANES{12'h111}}, 12'h150, 1'b0);
    chk("R4 rejoin pc", 32'(top_pc_o), 32'h130);
    chk("R4 rejoin mask", 32'(top_mask_o), 32'hFF);

    // R7 equal reconvergence PCs: no extra entry
    do_launch(12'h100, 8'hFF);
    do_update("R7 equal rpc", '0, pcs_hi_lo(12'h010, 12'h020), 12'hFFF, 1'b0);
    chk("R7 equal idx", 32'(top_idx_o), 32'(1));

    // R8 group landing on branch reconvergence PC after divergence is dropped
    do_launch(12'h100, 8'hFF);
    do_update("R8 drop", '0, pcs_hi_lo(12'h300, 12'h050), 12'h300, 1'b0);
    chk("R8 idx", 32'(top_idx_o), 32'(1));
    chk("R8 mask", 32'(top_mask_o), 32'h0F);

    // R11 PC 0 marker merges early zero lanes into the first non-zero group
    do_launch(12'h100, 8'hFF);
    pv = {LANES{12'h040}};
    pv[7*PC_W +: PC_W] = '0; pv[6*PC_W +: PC_W] = '0; pv[2*PC_W +: PC_W] = '0;
    do_update("R11 zero pc", '0, pv, 12'h090, 1'b0);
    chk("R11 idx", 32'(top_idx_o), 32'(2));
    chk("R11 mask", 32'(top_mask_o), 32'h04);
    chk("R11 pc", 32'(top_pc_o), 32'h000);
    chk("R11 rpc", 32'(top_rpc_o), 32'h090);

    // R12 empty top mask
    do_launch(12'h100, 8'h00);
    do_update("R12 empty", '0, {LANES{12'h010}}, 12'h020, 1'b0);
    chk("R12 empty err", 32'(err_o), 32'(1));
    do_launch(12'h100, 8'hFF);
    chk("R2 err cleared", 32'(err_o), 32'(0));

    // R12 underflow: every lane done at index 0
    do_update("R12 underflow", 8'hFF, {LANES{12'h010}}, 12'h020, 1'b0);
    chk("R12 underflow err", 32'(err_o), 32'(1));
    chk("R12 underflow idx", 32'(top_idx_o), 32'(0));

    // random mix (R4 R5 R6 R7 R8 R9 R10 R12)
    for (int n = 0; n < 400; n++) begin
      if (m_err || m_mask[m_top] == '0 || ($urandom % 10) == 0) begin
        do_launch(12'h100 + 12'($urandom % 64), 8'($urandom | 1));
        cmp_top("R2 rnd launch");
      end else begin
        logic [LANES-1:0] dn;
        logic [PC_W-1:0] br;
        dn = '0;
        for (int i = 0; i < LANES; i++) dn[i] = (($urandom % 8) == 0);
        for (int i = 0; i < LANES; i++) pv[i*PC_W +: PC_W] = rnd_pc();
        br = ($urandom % 4 == 0) ? 12'hFFF : (($urandom % 2) ? 12'h030 : 12'h050);
        do_update("R5 rnd update", dn, pv, br, ($urandom % 4) == 0);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule